// File: doc/BRIEF.md
# Load Store-Conflict Check Unit

In a speculative core, stores keep their address and data in reorder-buffer entries and write memory only when they commit, one at a time and in program order. Before a load may perform its memory access, this unit looks at every uncommitted store entry. It reports whether the load can proceed, or whether it has to wait because an older store writes the same location or has not yet computed its address. The age of an entry is its circular distance from the current reorder-buffer head. Only stores older than the load are taken into account.

When forwarding is enabled and the youngest older store that writes the same word has exactly the load's address and its data ready, the unit hands that data to the load and grants the access. In every other conflicting case it holds the load off. The decision is formed combinationally from a snapshot of the store entries and is registered once. A pipeline flush clears the registered verdict.

Top module: `load_raw_check`

## Requirements
- R1: While `rst_n` is low, `grant_o`, `fwd_valid_o` and `fwd_data_o` are zero on the following clock edge.
- R2: If the load is valid and every older valid store has a known address that lies in a different word, then one cycle later `grant_o`=1 and `fwd_valid_o`=0. A word is the byte address with its low log2(WORD_BYTES) bits dropped.
- R3: If any older valid store has `st_addr_known_i`=0, then one cycle later `grant_o`=0, whatever the other entries hold.
- R4: If forwarding is off (`fwd_en_i`=0), an older valid store with a known address in the load's word holds the load: `grant_o`=0 one cycle later.
- R5: A store counts as older only when (store tag − head) mod ROB_DEPTH is smaller than (load tag − head) mod ROB_DEPTH. Stores that are not older never block and never forward, even when their address is unknown.
- R6: If `fwd_en_i`=1, no older store has an unknown address, and the youngest older store in the load's word has an address equal to the load's on all bits and `st_data_ready_i`=1, then one cycle later `grant_o`=1, `fwd_valid_o`=1 and `fwd_data_o` equals that store's data.
- R7: When several older stores hit the load's word, only the youngest one (the largest distance from head) decides whether the load blocks or forwards, and it is the one that supplies the data.
- R8: If the youngest hitting store has an exact address match but `st_data_ready_i`=0, the load is blocked (`grant_o`=0) even with forwarding on.
- R9: A partial overlap is treated as a blocking conflict: same word but different low address bits holds the load, even with forwarding on.
- R10: `flush_i`=1 forces `grant_o`, `fwd_valid_o` and `fwd_data_o` to zero one cycle later.
- R11: With `ld_valid_i`=0, all outputs are zero one cycle later. `fwd_data_o` is zero whenever `fwd_valid_o` is 0.
- R12: Store entries with `st_valid_i`=0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Flush; clears the registered verdict |
| fwd_en_i | input | 1 | Enables store-to-load data forwarding |
| ld_valid_i | input | 1 | A load is presented for checking |
| ld_addr_i | input | ADDR_W | Load byte address |
| ld_tag_i | input | TAG_W | Reorder-buffer index of the load |
| rob_head_i | input | TAG_W | Reorder-buffer head index (oldest entry) |
| st_valid_i | input | NUM_ST | Store entry occupied and uncommitted |
| st_addr_known_i | input | NUM_ST | Store address has been computed |
| st_data_ready_i | input | NUM_ST | Store data is available |
| st_tag_i | input | NUM_ST*TAG_W | Reorder-buffer index of each store, entry i at bits [i*TAG_W +: TAG_W] |
| st_addr_i | input | NUM_ST*ADDR_W | Store byte addresses, entry i at [i*ADDR_W +: ADDR_W] |
| st_data_i | input | NUM_ST*DATA_W | Store data, entry i at [i*DATA_W +: DATA_W] |
| grant_o | output | 1 | Load may perform its memory access (registered) |
| fwd_valid_o | output | 1 | Load takes its value from `fwd_data_o` (registered) |
| fwd_data_o | output | DATA_W | Forwarded store data, zero when not forwarding |

## Verification
The assertions take for granted that ROB_DEPTH is a power of two and that valid store entries carry distinct reorder-buffer tags. They also assume that the load tag differs from every valid store tag, because an equal tag is simply treated as not older. The bench gives each valid store a distinct tag by spacing the tags two apart from a common base, and it sweeps every head and load-tag pair with both forwarding settings. The store addresses come from a small pool. That pool forces exact hits, partial same-word hits and misses, and unknown addresses and data readiness are mixed in at fixed proportions.

// File: rtl/lrc_pkg.sv
// Package: shared verdict type for the load store-conflict check unit.
// Assumes nothing beyond being compiled before the modules that import it.
package lrc_pkg;

    typedef enum logic [1:0] {
        LRC_BLOCK   = 2'd0,
        LRC_GRANT   = 2'd1,
        LRC_FORWARD = 2'd2
    } lrc_verdict_e;

endpackage

// File: rtl/lrc_entry_cmp.sv
// Module: lrc_entry_cmp
// Compares one store entry against the presented load. It classifies the store
// as older or not from circular distances to the reorder-buffer head, flags an
// unknown address on an older store, and reports word-level and exact hits.
// Assumes the tag width equals log2 of a power-of-two reorder-buffer depth, so
// unsigned subtraction wraps exactly modulo the depth.
module lrc_entry_cmp #(
    parameter int ADDR_W = 8,
    parameter int TAG_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic              st_valid_i,
    input  logic              st_known_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [TAG_W-1:0]  st_tag_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [TAG_W-1:0]  ld_tag_i,
    input  logic [TAG_W-1:0]  head_i,
    output logic              unknown_o,
    output logic              word_hit_o,
    output logic              exact_hit_o,
    output logic [TAG_W-1:0]  dist_o
);

    logic [TAG_W-1:0] ld_dist;
    logic             is_older;
    logic             same_word;
    logic             same_off;

    // Purpose: circular distances from the head and the resulting age order.
    always_comb begin
        dist_o   = st_tag_i - head_i;
        ld_dist  = ld_tag_i - head_i;
        is_older = st_valid_i && (dist_o < ld_dist);
    end

    // Purpose: split the address compare into word part and in-word offset.
    always_comb begin
        same_word = (st_addr_i[ADDR_W-1:OFF_W] == ld_addr_i[ADDR_W-1:OFF_W]);
        same_off  = (st_addr_i[OFF_W-1:0] == ld_addr_i[OFF_W-1:0]);
    end

    // Purpose: classify the entry for the picker and the decision logic.
    always_comb begin
        unknown_o   = is_older && !st_known_i;
        word_hit_o  = is_older && st_known_i && same_word;
        exact_hit_o = word_hit_o && same_off;
    end

endmodule

// File: rtl/lrc_youngest_pick.sv
// Module: lrc_youngest_pick
// Among entries flagged as hits, selects the one farthest from the head, that
// is, the youngest older store. Assumes hitting entries carry distinct
// distances (distinct tags). On a tie the lowest index wins.
module lrc_youngest_pick #(
    parameter int NUM_ST = 4,
    parameter int TAG_W  = 3,
    parameter int SEL_W  = 2
) (
    input  logic [NUM_ST-1:0]       hit_i,
    input  logic [NUM_ST*TAG_W-1:0] dist_i,
    output logic                    found_o,
    output logic [SEL_W-1:0]        sel_o
);

    logic [TAG_W-1:0] best_dist;
    logic [TAG_W-1:0] sel_dist;

    // Purpose: linear scan keeping the hit with the largest head distance.
    always_comb begin
        found_o   = 1'b0;
        sel_o     = '0;
        best_dist = '0;
        for (int i = 0; i < NUM_ST; i++) begin
            if (hit_i[i] && (!found_o || dist_i[i*TAG_W +: TAG_W] > best_dist)) begin
                found_o   = 1'b1;
                sel_o     = SEL_W'(i);
                best_dist = dist_i[i*TAG_W +: TAG_W];
            end
        end
    end

    // Purpose: distance of the chosen entry, read back for the check below.
    always_comb sel_dist = dist_i[sel_o*TAG_W +: TAG_W];

    // Purpose: no hitting entry may be younger than the selected one.
    always_comb begin
        for (int j = 0; j < NUM_ST; j++) begin
            if (found_o && hit_i[j]) begin
                assert_youngest_pick_R7: assert (dist_i[j*TAG_W +: TAG_W] <= sel_dist);
            end
        end
    end

endmodule

// File: rtl/lrc_decide.sv
// Module: lrc_decide
// Turns the per-load summary into a verdict: block, plain grant, or grant with
// forwarding. An unknown older address dominates. Any hit without a ready,
// exact youngest source blocks.
module lrc_decide
    import lrc_pkg::*;
(
    input  logic         ld_valid_i,
    input  logic         fwd_en_i,
    input  logic         any_unknown_i,
    input  logic         found_i,
    input  logic         sel_exact_i,
    input  logic         sel_ready_i,
    output lrc_verdict_e verdict_o
);

    // Purpose: priority-ordered verdict selection.
    always_comb begin
        if (!ld_valid_i || any_unknown_i) begin
            verdict_o = LRC_BLOCK;
        end else if (!found_i) begin
            verdict_o = LRC_GRANT;
        end else if (fwd_en_i && sel_exact_i && sel_ready_i) begin
            verdict_o = LRC_FORWARD;
        end else begin
            verdict_o = LRC_BLOCK;
        end
    end

endmodule

// File: rtl/load_raw_check.sv
// Module: load_raw_check (top)
// Decides whether a load may access memory while older stores still wait in
// the reorder buffer, and optionally forwards the youngest matching store's
// data. The decision is combinational and registered once. Flush and reset
// clear the register. Assumes ROB_DEPTH is a power of two, valid stores carry
// distinct tags, and the load tag differs from every valid store tag.
module load_raw_check
    import lrc_pkg::*;
#(
    parameter int ROB_DEPTH  = 8,
    parameter int NUM_ST     = 4,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int WORD_BYTES = 4,
    localparam int TAG_W     = $clog2(ROB_DEPTH),
    localparam int OFF_W     = $clog2(WORD_BYTES),
    localparam int SEL_W     = (NUM_ST > 1) ? $clog2(NUM_ST) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush_i,
    input  logic                     fwd_en_i,
    input  logic                     ld_valid_i,
    input  logic [ADDR_W-1:0]        ld_addr_i,
    input  logic [TAG_W-1:0]         ld_tag_i,
    input  logic [TAG_W-1:0]         rob_head_i,
    input  logic [NUM_ST-1:0]        st_valid_i,
    input  logic [NUM_ST-1:0]        st_addr_known_i,
    input  logic [NUM_ST-1:0]        st_data_ready_i,
    input  logic [NUM_ST*TAG_W-1:0]  st_tag_i,
    input  logic [NUM_ST*ADDR_W-1:0] st_addr_i,
    input  logic [NUM_ST*DATA_W-1:0] st_data_i,
    output logic                     grant_o,
    output logic                     fwd_valid_o,
    output logic [DATA_W-1:0]        fwd_data_o
);

    logic [NUM_ST-1:0]       unknown_vec;
    logic [NUM_ST-1:0]       word_hit_vec;
    logic [NUM_ST-1:0]       exact_vec;
    logic [NUM_ST*TAG_W-1:0] dist_vec;
    logic                    any_unknown;
    logic                    found;
    logic [SEL_W-1:0]        sel;
    logic                    sel_exact;
    logic                    sel_ready;
    logic [DATA_W-1:0]       sel_data;
    lrc_verdict_e            verdict;

    // One comparator per store entry.
    for (genvar g = 0; g < NUM_ST; g++) begin : g_entry
        lrc_entry_cmp #(
            .ADDR_W (ADDR_W),
            .TAG_W  (TAG_W),
            .OFF_W  (OFF_W)
        ) cmp_i (
            .st_valid_i  (st_valid_i[g]),
            .st_known_i  (st_addr_known_i[g]),
            .st_addr_i   (st_addr_i[g*ADDR_W +: ADDR_W]),
            .st_tag_i    (st_tag_i[g*TAG_W +: TAG_W]),
            .ld_addr_i   (ld_addr_i),
            .ld_tag_i    (ld_tag_i),
            .head_i      (rob_head_i),
            .unknown_o   (unknown_vec[g]),
            .word_hit_o  (word_hit_vec[g]),
            .exact_hit_o (exact_vec[g]),
            .dist_o      (dist_vec[g*TAG_W +: TAG_W])
        );
    end

    lrc_youngest_pick #(
        .NUM_ST (NUM_ST),
        .TAG_W  (TAG_W),
        .SEL_W  (SEL_W)
    ) pick_i (
        .hit_i   (word_hit_vec),
        .dist_i  (dist_vec),
        .found_o (found),
        .sel_o   (sel)
    );

    // Purpose: reduce unknown flags and fetch the selected entry's attributes.
    always_comb begin
        any_unknown = |unknown_vec;
        sel_exact   = exact_vec[sel];
        sel_ready   = st_data_ready_i[sel];
        sel_data    = st_data_i[sel*DATA_W +: DATA_W];
    end

    lrc_decide decide_i (
        .ld_valid_i    (ld_valid_i),
        .fwd_en_i      (fwd_en_i),
        .any_unknown_i (any_unknown),
        .found_i       (found),
        .sel_exact_i   (sel_exact),
        .sel_ready_i   (sel_ready),
        .verdict_o     (verdict)
    );

    // Purpose: register the verdict; reset and flush clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            grant_o     <= 1'b0;
            fwd_valid_o <= 1'b0;
            fwd_data_o  <= '0;
        end else begin
            grant_o     <= (verdict != LRC_BLOCK);
            fwd_valid_o <= (verdict == LRC_FORWARD);
            fwd_data_o  <= (verdict == LRC_FORWARD) ? sel_data : '0;
        end
    end

    assert_unknown_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_i && (|unknown_vec)) |=> !grant_o);

    assert_not_ready_no_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !st_data_ready_i[sel]) |=> !fwd_valid_o);

    assert_fwd_needs_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid_o |-> grant_o);

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!grant_o && !fwd_valid_o && fwd_data_o == '0));

    assert_idle_no_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid_i |=> (!grant_o && !fwd_valid_o));

    assert_partial_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !exact_vec[sel]) |=> !grant_o);

endmodule

// File: tb/load_raw_check_tb_top.sv
`timescale 1ns/1ps
module load_raw_check_tb_top;

    localparam int D  = 8;
    localparam int NS = 4;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int TW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic fe = 1'b0;
    logic lv = 1'b0;
    logic [AW-1:0] la = '0;
    logic [TW-1:0] lt = '0;
    logic [TW-1:0] hd = '0;
    logic [NS-1:0] sv = '0, sk = '0, sr = '0;
    logic [TW-1:0] stg [NS];
    logic [AW-1:0] sa  [NS];
    logic [DW-1:0] sd  [NS];
    logic [NS*TW-1:0] tag_bus;
    logic [NS*AW-1:0] addr_bus;
    logic [NS*DW-1:0] data_bus;
    logic grant, fwdv;
    logic [DW-1:0] fwdd;

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            tag_bus[i*TW +: TW]  = stg[i];
            addr_bus[i*AW +: AW] = sa[i];
            data_bus[i*DW +: DW] = sd[i];
        end
    end

    load_raw_check dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .fwd_en_i(fe),
        .ld_valid_i(lv), .ld_addr_i(la), .ld_tag_i(lt), .rob_head_i(hd),
        .st_valid_i(sv), .st_addr_known_i(sk), .st_data_ready_i(sr),
        .st_tag_i(tag_bus), .st_addr_i(addr_bus), .st_data_i(data_bus),
        .grant_o(grant), .fwd_valid_o(fwdv), .fwd_data_o(fwdd)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic eg, input logic ef, input logic [DW-1:0] ed);
        vectors++;
        if (grant !== eg || fwdv !== ef || fwdd !== ed) begin
            errors++;
            $display("FAIL %s: grant/fwd/data got %b/%b/%h expected %b/%b/%h",
                     req, grant, fwdv, fwdd, eg, ef, ed);
        end
    endtask

    // Reference model built from the requirements; also names the rule used.
    task automatic model(output logic eg, output logic ef, output logic [DW-1:0] ed, output string req);
        bit unk = 0, fnd = 0;
        int best = 0;
        int bd = 0;
        int dl = (int'(lt) - int'(hd) + D) % D;
        for (int i = 0; i < NS; i++) begin
            int ds = (int'(stg[i]) - int'(hd) + D) % D;
            if (sv[i] && ds < dl) begin
                if (!sk[i]) unk = 1;
                else if ((sa[i] >> 2) == (la >> 2) && (!fnd || ds > bd)) begin
                    fnd = 1; best = i; bd = ds;
                end
            end
        end
        eg = 0; ef = 0; ed = '0;
        if (!lv) req = "R11";
        else if (unk) req = "R3";
        else if (!fnd) begin req = "R2"; eg = 1; end
        else if (!fe) req = "R4";
        else if (sa[best] != la) req = "R9";
        else if (!sr[best]) req = "R8";
        else begin req = "R6"; eg = 1; ef = 1; ed = sd[best]; end
    endtask

    task automatic clear_stores();
        sv = '0; sk = '1; sr = '1;
        for (int i = 0; i < NS; i++) begin
            stg[i] = TW'(i); sa[i] = 8'h00; sd[i] = 8'h00;
        end
    endtask

    function automatic logic [AW-1:0] pool(input logic [1:0] s);
        case (s)
            2'd0: return 8'h40;
            2'd1: return 8'h41;
            2'd2: return 8'h44;
            default: return 8'h80;
        endcase
    endfunction

    initial begin
        logic eg, ef;
        logic [DW-1:0] ed;
        string rq;
        clear_stores();
        // R1: outputs idle under reset, even with a grantable load present
        lv = 1; la = 8'h40; lt = 3'd5; hd = 3'd0;
        step(); step();
        check("R1", 0, 0, 8'h00);
        rst_n = 1'b1;
        step();
        check("R2 no stores", 1, 0, 8'h00);

        // R12: invalid older entry in the same word is ignored
        sv = 4'b0000; sk = 4'b0000; stg[0] = 3'd1; sa[0] = 8'h40; fe = 0;
        step();
        check("R12", 1, 0, 8'h00);

        // R5: wrap-around; head 6, load tag 1; store tag 3 is younger
        clear_stores(); hd = 3'd6; lt = 3'd1; la = 8'h44;
        sv = 4'b0011; stg[0] = 3'd3; sa[0] = 8'h44; sk = 4'b1110;
        stg[1] = 3'd7; sa[1] = 8'h80;
        step();
        check("R5 younger ignored", 1, 0, 8'h00);
        sk = 4'b1111; sa[1] = 8'h44; fe = 0;
        step();
        check("R5 wrapped older blocks", 0, 0, 8'h00);

        // R7: two exact older hits across the wrap; the youngest supplies data
        clear_stores(); hd = 3'd6; lt = 3'd3; la = 8'h41; fe = 1;
        sv = 4'b0011; stg[0] = 3'd7; sa[0] = 8'h41; sd[0] = 8'h11;
        stg[1] = 3'd1; sa[1] = 8'h41; sd[1] = 8'h22;
        step();
        check("R7 youngest data", 1, 1, 8'h22);
        sa[1] = 8'h40;
        step();
        check("R7 youngest partial blocks", 0, 0, 8'h00);

        // R10: flush overrides a forwarding verdict
        sa[1] = 8'h41; flush = 1;
        step();
        check("R10", 0, 0, 8'h00);
        flush = 0;
        step();
        check("R6 after flush", 1, 1, 8'h22);

        // R11: no load, no grant
        lv = 0;
        step();
        check("R11", 0, 0, 8'h00);
        lv = 1;

        // Sweep: every head and load tag, both forwarding modes
        for (int f = 0; f < 2; f++) begin
            for (int h = 0; h < D; h++) begin
                for (int t = 0; t < D; t++) begin
                    for (int rep = 0; rep < 12; rep++) begin
                        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        fe = f[0]; hd = TW'(h); lt = TW'(t);
                        la = pool(lfsr[1:0]);
                        for (int i = 0; i < NS; i++) begin
                            logic [15:0] r = lfsr ^ (16'h9E37 * 16'(i + 1));
                            stg[i] = TW'(int'(lfsr[4:2]) + 2 * i);
                            sv[i] = r[3] | r[7];
                            sk[i] = r[5] | r[9] | r[11];
                            sr[i] = r[6] | r[12];
                            sa[i] = pool(r[1:0]);
                            sd[i] = r[15:8];
                        end
                        step();
                        model(eg, ef, ed, rq);
                        check(rq, eg, ef, ed);
                    end
                end
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule